// File: doc/BRIEF.md
# I2C Target with Sparse 16-bit Configuration Registers

This block is a two-wire serial target that holds a small set of 16-bit configuration words. A bus controller addresses it on a fixed 7-bit device address. It then selects one word through a 16-bit register pointer and writes or reads that word as two bytes, high byte first. The block samples the clock and data lines with its own faster system clock. It drives the data line only by pulling it low, through an output-enable. Every stored word is also presented in parallel on one flat output bus, so that neighbouring logic can use the configuration directly.

A write transaction sends the device address with the direction bit clear, then the pointer high and low bytes, then the data high and low bytes, and ends with STOP. A read transaction first sets the pointer with the same addressed write and no data. It then issues a repeated START with the direction bit set, and the block returns the selected word in two bytes. The word map is sparse: twelve even addresses are implemented. Any other pointer value reads as zero, and writes to it are accepted but dropped.

Top module: `i2c_cfg_regbank`

## Requirements
- R1: The block acknowledges only the device address 7'b0000111. On the wire the address byte is 0x0E for a write (direction bit 0) and 0x0F for a read (direction bit 1). The block acknowledges each address, pointer and data byte of a write by holding the data line low during the ninth clock.
- R2: After a device address byte that does not match, the block does not acknowledge and does not drive the data line until the next START. No stored word changes.
- R3: In a write, the first two bytes after the address form the pointer, high byte first. The next two bytes form the data word, high byte first. The addressed word updates only after the data low byte has been received and acknowledged.
- R4: In a read (a direction-bit-1 address after the pointer has been set), the block returns the pointed word as high byte then low byte, most significant bit first.
- R5: The implemented pointers are 0x0002, 0x0004, 0x0006, 0x0008, 0x000C, 0x0010, 0x0014, 0x0016, 0x0018, 0x0020, 0x0022 and 0x0060. Slot k in this order appears on cfg_words[16k+15:16k].
- R6: A write to an unimplemented pointer is acknowledged on every byte and changes no stored word.
- R7: A read of an unimplemented or odd pointer returns 0x0000.
- R8: A new START, or a repeated START, keeps the pointer. A read frame with no pointer bytes returns the word that the last pointer selected.
- R9: When the controller does not acknowledge the first read byte, the block releases the data line and drives nothing until STOP or START.
- R10: Synchronous reset clears every stored word to 0x0000 and releases the data line.
- R11: A write frame that ends with STOP before the data low byte changes no stored word.
- R12: The block changes its data-line drive only while the sampled clock line is low, except when it releases on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| cfg_words | output | 192 | All stored words; slot k at bits [16k+15:16k] |

## Verification
Writes are sent to each of the twelve implemented pointers with distinct values. This shows whether the pointer decode puts each word in its own output slot, or whether two addresses alias. Reads at the low and high ends of the map, at an unmapped even pointer and at an odd pointer tell a correct read path apart from one that ignores the hit decode. A wrong device address, a frame cut short after the data high byte, and a write to an unmapped pointer each have to leave the stored image unchanged. A read frame without pointer bytes, and a controller that refuses the first read byte, exercise pointer retention and bus release.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 12;

    typedef logic [WORD_W-1:0] word_t;

    // Slot order fixes the position of each word on the flat output bus
    localparam word_t REG_MAP [NUM_REGS] = '{
        16'h0002, 16'h0004, 16'h0006, 16'h0008, 16'h000C, 16'h0010,
        16'h0014, 16'h0016, 16'h0018, 16'h0020, 16'h0022, 16'h0060
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [2:0]        byte_idx;
        logic              rw;
        word_t             ptr;
        logic [BYTE_W-1:0] data_hi;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] tx_lo;
        logic              tx_second;
        logic              m_ack;
        logic              sda_oe;
        logic              wr_en;
        word_t             wr_data;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe_d, scl_pipe_q;
    logic [PIPE_W-1:0] sda_pipe_d, sda_pipe_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    logic scl_prev, sda_prev;

    assign scl_s    = scl_pipe_q[STAGES-1];
    assign sda_s    = sda_pipe_q[STAGES-1];
    assign scl_prev = scl_pipe_q[STAGES];
    assign sda_prev = sda_pipe_q[STAGES];

    assign scl_rise  = scl_s && !scl_prev;
    assign scl_fall  = !scl_s && scl_prev;
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0000111
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_s,
    input  logic  sda_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_det,
    input  logic  stop_det,
    input  word_t rd_data,
    output word_t ptr,
    output logic  wr_en,
    output word_t wr_data,
    output logic  sda_oe
);

    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] FULL_CNT = 4'd8;
    localparam logic [2:0] IDX_SAT  = 3'd4;

    tgt_regs_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_det) begin
            d.state    = ST_DEV;
            d.bitcnt   = '0;
            d.byte_idx = '0;
            d.sda_oe   = 1'b0;
        end else if (stop_det) begin
            d.state  = ST_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: ;
                ST_DEV, ST_RX: begin
                    if (scl_rise && q.bitcnt < FULL_CNT) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                    if (scl_fall && q.bitcnt == FULL_CNT) begin
                        if (q.state == ST_RX) begin
                            d.sda_oe = 1'b1;
                            d.state  = ST_RX_ACK;
                        end else if (q.shreg[7:1] == DEV_ADDR) begin
                            d.rw     = q.shreg[0];
                            d.sda_oe = 1'b1;
                            d.state  = ST_DEV_ACK;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.tx        = rd_data[15:8];
                            d.tx_lo     = rd_data[7:0];
                            d.tx_second = 1'b0;
                            d.sda_oe    = ~rd_data[15];
                            d.state     = ST_TX;
                        end else begin
                            d.sda_oe   = 1'b0;
                            d.byte_idx = '0;
                            d.state    = ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.bitcnt = '0;
                        d.state  = ST_RX;
                        case (q.byte_idx)
                            3'd0: d.ptr[15:8] = q.shreg;
                            3'd1: d.ptr[7:0]  = q.shreg;
                            3'd2: d.data_hi   = q.shreg;
                            3'd3: begin
                                d.wr_en   = 1'b1;
                                d.wr_data = {q.data_hi, q.shreg};
                            end
                            default: ;
                        endcase
                        if (q.byte_idx != IDX_SAT) d.byte_idx = q.byte_idx + 3'd1;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                        d.tx     = {q.tx[BYTE_W-2:0], 1'b0};
                        if (q.bitcnt == LAST_BIT) begin
                            d.sda_oe = 1'b0;
                            d.state  = ST_TX_ACK;
                        end else begin
                            d.sda_oe = ~q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) d.m_ack = !sda_s;
                    if (scl_fall) begin
                        if (q.m_ack && !q.tx_second) begin
                            d.tx        = q.tx_lo;
                            d.tx_second = 1'b1;
                            d.bitcnt    = '0;
                            d.sda_oe    = ~q.tx_lo[BYTE_W-1];
                            d.state     = ST_TX;
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: ;
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ptr     = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_data = q.wr_data;
    assign sda_oe  = q.sda_oe;

    AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.sda_oe) |-> (!scl_s || $past(start_det || stop_det))); // R12
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_IDLE) |-> !q.sda_oe); // R2
    AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        q.wr_en |-> ($past(q.sda_oe) && !q.sda_oe && $past(q.state) == ST_RX_ACK)); // R3
    AST_RELEASE_FOR_MASTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_TX_ACK || q.state == ST_HOLD) |-> !q.sda_oe); // R9

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import i2c_cfg_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  word_t             wr_addr,
    input  word_t             wr_data,
    input  word_t             rd_addr,
    output word_t             rd_data,
    output logic [N*WORD_W-1:0] words
);

    logic [N-1:0][WORD_W-1:0] words_d, words_q;
    logic [N-1:0]             wr_hit;
    logic [N-1:0]             rd_hit;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign wr_hit[g] = (wr_addr == REG_MAP[g]);
        assign rd_hit[g] = (rd_addr == REG_MAP[g]);
        assign words[g*WORD_W +: WORD_W] = words_q[g];

        AST_HOLD_UNLESS_WRITTEN: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_hit[g]) |=> $stable(words_q[g])); // R6
    end

    always_comb begin
        words_d = words_q;
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (wr_en && wr_hit[i]) words_d[i] = wr_data;
            if (rd_hit[i])          rd_data    = rd_data | words_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) words_q <= '0;
        else     words_q <= words_d;
    end

endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0000111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe,
    output logic [NUM_REGS*WORD_W-1:0]   cfg_words
);

    logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    word_t ptr, rd_data, wr_data;
    logic  wr_en;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_reg_file #(.N(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .words   (cfg_words)
    );

endmodule

// File: tb/tb_i2c_cfg_regbank.sv
module tb_i2c_cfg_regbank;

    localparam int Q     = 10;
    localparam int NREG  = 12;
    localparam logic [15:0] MAP [NREG] = '{
        16'h0002, 16'h0004, 16'h0006, 16'h0008, 16'h000C, 16'h0010,
        16'h0014, 16'h0016, 16'h0018, 16'h0020, 16'h0022, 16'h0060
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic [NREG*16-1:0] cfg_words;
    logic scl_bus, sda_bus;

    assign scl_bus = !m_scl_low;
    assign sda_bus = !(m_sda_low || sda_oe);

    always #4 clk = ~clk;

    i2c_cfg_regbank dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .cfg_words (cfg_words)
    );

    int total = 0;
    int fails = 0;
    logic [15:0] model [NREG];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] act_q [$];
    int          r12_viol = 0;
    logic        oe_prev = 1'b0;
    bit          done = 1'b0;

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; qwait();
        m_scl_low = 1'b0; qwait();
        m_sda_low = 1'b1; qwait();
        m_scl_low = 1'b1; qwait();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; qwait();
        m_scl_low = 1'b0; qwait();
        m_sda_low = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; qwait();
            m_scl_low = 1'b0;  qwait(); qwait();
            m_scl_low = 1'b1;  qwait();
        end
        m_sda_low = 1'b0; qwait();
        m_scl_low = 1'b0; qwait();
        ack = !sda_bus;   qwait();
        m_scl_low = 1'b1; qwait();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            m_scl_low = 1'b0; qwait();
            b[i] = sda_bus;   qwait();
            m_scl_low = 1'b1; qwait();
        end
        m_sda_low = give_ack; qwait();
        m_scl_low = 1'b0;     qwait(); qwait();
        m_scl_low = 1'b1;     qwait();
        m_sda_low = 1'b0;
    endtask

    function automatic logic [191:0] model_flat();
        logic [191:0] f;
        for (int k = 0; k < NREG; k++) f[k*16 +: 16] = model[k];
        return f;
    endfunction

    function automatic void model_write(input logic [15:0] a, input logic [15:0] v);
        for (int k = 0; k < NREG; k++) if (MAP[k] == a) model[k] = v;
    endfunction

    function automatic logic [15:0] model_read(input logic [15:0] a);
        for (int k = 0; k < NREG; k++) if (MAP[k] == a) return model[k];
        return 16'h0000;
    endfunction

    // full write frame; returns AND of all acks
    task automatic wr_frame(input logic [7:0] dev, input logic [15:0] a,
                            input logic [15:0] v, output logic all_ack);
        logic ak;
        all_ack = 1'b1;
        bus_start();
        put_byte(dev, ak);      all_ack &= ak;
        put_byte(a[15:8], ak);  all_ack &= ak;
        put_byte(a[7:0], ak);   all_ack &= ak;
        put_byte(v[15:8], ak);  all_ack &= ak;
        put_byte(v[7:0], ak);   all_ack &= ak;
        bus_stop();
    endtask

    // driver: pointer set, repeated START, read; expected pushed to scoreboard
    task automatic rd_frame(input logic [15:0] a, input string tag, output logic all_ack);
        logic ak;
        logic [7:0] hi, lo;
        all_ack = 1'b1;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        bus_start();
        put_byte(8'h0E, ak);    all_ack &= ak;
        put_byte(a[15:8], ak);  all_ack &= ak;
        put_byte(a[7:0], ak);   all_ack &= ak;
        bus_start();
        put_byte(8'h0F, ak);    all_ack &= ak;
        get_byte(1'b1, hi);
        get_byte(1'b0, lo);
        bus_stop();
        act_q.push_back({hi, lo});
    endtask

    // monitor: pops expected and actual words as reads complete
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [15:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {176'd0, a}, {176'd0, e});
            end
        end
    end

    // R12: drive changes only while the bus clock is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && scl_bus) r12_viol++;
        oe_prev = sda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic ok;
        logic ak;
        logic [7:0] hi, lo, junk;
        for (int k = 0; k < NREG; k++) model[k] = 16'h0000;
        repeat (5) @(posedge clk);
        #1;
        // R10: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R10 words after reset", cfg_words, 192'd0);
        check("R10 sda released", {191'd0, sda_oe}, 192'd0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;

        // R1 R3: basic write
        wr_frame(8'h0E, 16'h0002, 16'hA55A, ok);
        model_write(16'h0002, 16'hA55A);
        check("R1 write frame acks", {191'd0, ok}, {191'd0, 1'b1});
        check("R3 word after write", cfg_words, model_flat());

        // R5: each slot distinct
        for (int k = 0; k < NREG; k++) begin
            logic [15:0] v;
            v = 16'h1000 + 16'(k) * 16'h0111 + 16'h0800;
            wr_frame(8'h0E, MAP[k], v, ok);
            model_write(MAP[k], v);
        end
        check("R5 slot placement", cfg_words, model_flat());

        // R4: reads at both ends of map
        rd_frame(16'h0016, "R4 read 0x0016", ok);
        check("R1 read frame acks", {191'd0, ok}, {191'd0, 1'b1});
        rd_frame(16'h0060, "R4 read 0x0060", ok);
        rd_frame(16'h0002, "R4 read 0x0002", ok);

        // R6: unmapped write acked, discarded
        wr_frame(8'h0E, 16'h0012, 16'hFFFF, ok);
        check("R6 unmapped write acks", {191'd0, ok}, {191'd0, 1'b1});
        check("R6 unmapped write no change", cfg_words, model_flat());

        // R7: unmapped and odd reads
        rd_frame(16'h0012, "R7 read unmapped", ok);
        rd_frame(16'h0003, "R7 read odd", ok);

        // R2: wrong device address
        bus_start();
        put_byte(8'h10, ak);
        check("R2 wrong address nack", {191'd0, ak}, 192'd0);
        put_byte(8'h00, ak);
        put_byte(8'h04, ak);
        check("R2 later byte not acked", {191'd0, ak}, 192'd0);
        put_byte(8'hDE, ak);
        put_byte(8'hAD, ak);
        bus_stop();
        check("R2 words unchanged", cfg_words, model_flat());

        // R11: frame cut after data high byte
        bus_start();
        put_byte(8'h0E, ak);
        put_byte(8'h00, ak);
        put_byte(8'h04, ak);
        put_byte(8'hAB, ak);
        bus_stop();
        repeat (8) @(posedge clk);
        #1;
        check("R11 short frame no change", cfg_words, model_flat());

        // R8: pointer retained across frames (last pointer 0x0004)
        exp_q.push_back(model_read(16'h0004));
        tag_q.push_back("R8 pointer kept");
        bus_start();
        put_byte(8'h0F, ak);
        get_byte(1'b1, hi);
        get_byte(1'b0, lo);
        bus_stop();
        act_q.push_back({hi, lo});

        // R9: controller refuses first byte
        bus_start();
        put_byte(8'h0E, ak);
        put_byte(8'h00, ak);
        put_byte(8'h08, ak);
        bus_start();
        put_byte(8'h0F, ak);
        get_byte(1'b0, hi);
        get_byte(1'b0, junk);
        bus_stop();
        check("R9 high byte still sent", {184'd0, hi}, {184'd0, model_read(16'h0008) >> 8});
        check("R9 released after nack", {184'd0, junk}, {184'd0, 8'hFF});

        wait (act_q.size() == 0);
        repeat (4) @(posedge clk);
        #1;
        check("R12 drive change with clock high", 192'(r12_viol), 192'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule